// File: doc/BRIEF.md
# Dual-Modulus Fractional Clock Divider

This block turns a fast reference clock into a slow periodic timing signal, for example a 32.768 kHz real-time tick taken from a 24 MHz crystal. It does not use one fixed integer divisor. It runs a first divisor for a programmed number of output periods, then a second divisor for another programmed number of periods, and repeats that pattern. The long-run division ratio is therefore the weighted mean (N1·M1 + N2·M2)/(M1 + M2), which can be fractional.

Software configures the block through two 32-bit control words written on a plain write port. The words carry both divisors, both repeat counts, a dual-mode enable, an input gate, an output gate and a bypass select. The block drives two outputs in the reference clock domain:
- a single-cycle enable pulse on the first input cycle of every output period;
- a near-square level that downstream logic can use as a toggled clock.

Nothing flows through the block as a stream, so it has no valid/ready handshake. Writes take effect on the clock edge that samples them.

Top module: `fdiv_top`

## Requirements
- R1: A write with select 0 loads control word A: N1 at bits 11:0, N2 at bits 23:12, dual enable at bit 28, output gate at bit 30, input gate at bit 31. A write with select 1 loads control word B: M1 at bits 11:0, M2 at bits 23:12, bypass at bit 24.
- R2: With dual enable clear, every output period lasts N1 enabled input cycles.
- R3: With dual enable set, the block produces M1 periods of N1 cycles, then M2 periods of N2 cycles, and repeats that order without end.
- R4: A divisor or repeat count programmed as 0 behaves exactly as 1.
- R5: The pulse is high only on the first cycle of each period. Outside bypass, the level is high for the first floor(N/2) cycles of a period of N cycles and low for the remaining cycles.
- R6: A new divisor takes effect at the next period boundary, and the period in progress completes with its old length. A change of dual enable from clear to set restarts the pattern at the first N1 period.
- R7: While the input gate is clear, the period counter does not advance, the pulse is low and the level holds its value.
- R8: While the output gate is clear, the pulse and the level are both low.
- R9: With bypass set and both gates set, the pulse and the level are high on every cycle.
- R10: After reset the control words hold their parameter values, and the first cycle after reset is the start of a period of the reset N1.
- R11: With N1=733, M1=8, N2=732, M2=11 in dual mode, 19 periods span exactly 13916 input cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Control word write strobe |
| wr_sel_i | input | 1 | Control word select (0 = word A, 1 = word B) |
| wr_data_i | input | 32 | Control word write data |
| pulse_o | output | 1 | One-cycle pulse at the start of each output period |
| wave_o | output | 1 | Divided level output |

## Verification
The assertions rely on the select input being a single bit, which always addresses one of the two words. They also rely on the zero-to-one mapping, which keeps the active divisor nonzero, so the counter bound and the wrap check stay well defined for every value software can write. Each stimulus sequence first reprograms a one-cycle divisor in single mode and lets it settle. The next configuration therefore starts on a known boundary, and the expected pulse and level pattern can be computed cycle by cycle from the written fields.

// File: rtl/fdiv_pkg.sv
package fdiv_pkg;
  localparam int FW        = 12;
  localparam int WORDS     = 2;
  localparam int WW        = 32;
  localparam int LO_LSB    = 0;
  localparam int HI_LSB    = 12;
  localparam int DUAL_BIT  = 28;
  localparam int OGATE_BIT = 30;
  localparam int IGATE_BIT = 31;
  localparam int BYP_BIT   = 24;

  typedef logic [FW-1:0] fval_t;

  typedef enum logic {SEG_A, SEG_B} seg_e;

  typedef struct packed {
    logic  in_en;
    logic  out_en;
    logic  dual;
    logic  bypass;
    fval_t n1;
    fval_t n2;
    fval_t m1;
    fval_t m2;
  } fcfg_t;

  function automatic fcfg_t unpack_cfg(input logic [WW-1:0] wa, input logic [WW-1:0] wb);
    fcfg_t c;
    c.n1     = wa[LO_LSB +: FW];
    c.n2     = wa[HI_LSB +: FW];
    c.dual   = wa[DUAL_BIT];
    c.out_en = wa[OGATE_BIT];
    c.in_en  = wa[IGATE_BIT];
    c.m1     = wb[LO_LSB +: FW];
    c.m2     = wb[HI_LSB +: FW];
    c.bypass = wb[BYP_BIT];
    return c;
  endfunction

  function automatic fval_t at_least_one(input fval_t v);
    return (v == '0) ? fval_t'(1) : v;
  endfunction
endpackage

// File: rtl/fdiv_regs.sv
module fdiv_regs
  import fdiv_pkg::*;
#(
  parameter logic [WW-1:0] RST_A = '0,
  parameter logic [WW-1:0] RST_B = '0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic          wr_sel_i,
  input  logic [WW-1:0] wr_data_i,
  output fcfg_t         cfg_o
);
  logic [WW-1:0] word_q [WORDS];

  for (genvar g = 0; g < WORDS; g++) begin : g_word
    localparam logic [WW-1:0] RV = (g == 0) ? RST_A : RST_B;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                               word_q[g] <= RV;
      else if (wr_en_i && (wr_sel_i == 1'(g)))   word_q[g] <= wr_data_i;
    end
  end

  assign cfg_o = unpack_cfg(word_q[0], word_q[1]);
endmodule

// File: rtl/fdiv_seq.sv
module fdiv_seq
  import fdiv_pkg::*;
#(
  parameter logic  RST_DUAL = 1'b0,
  parameter fval_t RST_M1   = fval_t'(1)
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  adv_i,
  input  fcfg_t cfg_i,
  output fval_t n_next_o
);
  seg_e  seg_q, seg_d;
  fval_t rep_q, rep_d;
  fval_t mcur_q, mcur_d;
  logic  dual_q, dual_d;
  fval_t n1e, n2e, m1e, m2e;

  assign n1e = at_least_one(cfg_i.n1);
  assign n2e = at_least_one(cfg_i.n2);
  assign m1e = at_least_one(cfg_i.m1);
  assign m2e = at_least_one(cfg_i.m2);

  always_comb begin
    seg_d    = seg_q;
    rep_d    = rep_q;
    mcur_d   = mcur_q;
    dual_d   = dual_q;
    n_next_o = n1e;
    if (!cfg_i.dual) begin
      seg_d  = SEG_A;
      rep_d  = '0;
      dual_d = 1'b0;
      mcur_d = m1e;
    end else if (!dual_q) begin
      seg_d  = SEG_A;
      rep_d  = '0;
      dual_d = 1'b1;
      mcur_d = m1e;
    end else if (rep_q == mcur_q - fval_t'(1)) begin
      rep_d = '0;
      if (seg_q == SEG_A) begin
        seg_d    = SEG_B;
        mcur_d   = m2e;
        n_next_o = n2e;
      end else begin
        seg_d    = SEG_A;
        mcur_d   = m1e;
        n_next_o = n1e;
      end
    end else begin
      rep_d    = rep_q + fval_t'(1);
      n_next_o = (seg_q == SEG_B) ? n2e : n1e;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seg_q  <= SEG_A;
      rep_q  <= '0;
      mcur_q <= at_least_one(RST_M1);
      dual_q <= RST_DUAL;
    end else if (adv_i) begin
      seg_q  <= seg_d;
      rep_q  <= rep_d;
      mcur_q <= mcur_d;
      dual_q <= dual_d;
    end
  end
endmodule

// File: rtl/fdiv_cnt.sv
module fdiv_cnt
  import fdiv_pkg::*;
#(
  parameter fval_t RST_N = fval_t'(1)
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  en_i,
  input  fval_t n_next_i,
  output fval_t cnt_o,
  output fval_t ncur_o,
  output logic  wrap_o,
  output logic  hi_o
);
  fval_t cnt_q, ncur_q;
  logic  last;

  assign last   = (cnt_q == ncur_q - fval_t'(1));
  assign wrap_o = en_i && last;
  assign hi_o   = (cnt_q < (ncur_q >> 1));
  assign cnt_o  = cnt_q;
  assign ncur_o = ncur_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      ncur_q <= at_least_one(RST_N);
    end else if (en_i) begin
      if (last) begin
        cnt_q  <= '0;
        ncur_q <= n_next_i;
      end else begin
        cnt_q  <= cnt_q + fval_t'(1);
      end
    end
  end
endmodule

// File: rtl/fdiv_top.sv
module fdiv_top
  import fdiv_pkg::*;
#(
  parameter logic [31:0] RST_CTL0 = {1'b1, 1'b1, 1'b0, 1'b1, 4'b0, 12'd732, 12'd733},
  parameter logic [31:0] RST_CTL1 = {7'b0, 1'b0, 12'd11, 12'd8}
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic        wr_sel_i,
  input  logic [31:0] wr_data_i,
  output logic        pulse_o,
  output logic        wave_o
);
  localparam fcfg_t RST_CFG = unpack_cfg(RST_CTL0, RST_CTL1);

  fcfg_t cfg;
  fval_t n_next, cnt_q, ncur_q;
  logic  wrap, hi;

  fdiv_regs #(.RST_A(RST_CTL0), .RST_B(RST_CTL1)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i),
    .wr_data_i(wr_data_i), .cfg_o(cfg)
  );

  fdiv_seq #(.RST_DUAL(RST_CFG.dual), .RST_M1(RST_CFG.m1)) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .adv_i(wrap), .cfg_i(cfg), .n_next_o(n_next)
  );

  fdiv_cnt #(.RST_N(RST_CFG.n1)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(cfg.in_en), .n_next_i(n_next),
    .cnt_o(cnt_q), .ncur_o(ncur_q), .wrap_o(wrap), .hi_o(hi)
  );

  assign pulse_o = cfg.out_en && cfg.in_en && (cfg.bypass || (cnt_q == '0));
  assign wave_o  = cfg.out_en && (cfg.bypass ? cfg.in_en : hi);
endmodule

// File: rtl/fdiv_chk.sv
module fdiv_chk
  import fdiv_pkg::*;
(
  input logic  clk_i,
  input logic  rst_ni,
  input logic  in_en,
  input logic  out_en,
  input logic  bypass,
  input fval_t cnt,
  input fval_t ncur,
  input logic  pulse,
  input logic  wave
);
  AST_OUT_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_en |-> (!pulse && !wave)); // R8
  AST_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_en |=> ($stable(cnt) && $stable(ncur))); // R7
  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt < ncur); // R2
  AST_DIV_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ncur != '0); // R4
  AST_BYPASS_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bypass && in_en && out_en) |-> (pulse && wave)); // R9
  AST_WRAP_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_en && (cnt == ncur - fval_t'(1))) |=> (cnt == '0)); // R5
  AST_PULSE_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pulse && !bypass) |-> (cnt == '0)); // R5
endmodule

bind fdiv_top fdiv_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .in_en(cfg.in_en), .out_en(cfg.out_en),
  .bypass(cfg.bypass), .cnt(cnt_q), .ncur(ncur_q), .pulse(pulse_o), .wave(wave_o)
);

// File: tb/sim_fdiv_top.sv
`timescale 1ns/1ps
module sim_fdiv_top;
  localparam logic [31:0] B_CTL0 = {1'b1, 1'b1, 1'b0, 1'b0, 4'b0, 12'd0, 12'd1};
  localparam logic [31:0] B_CTL1 = {7'b0, 1'b0, 12'd1, 12'd1};

  logic clk_i = 1'b0, rst_ni = 1'b0, wr_en_i = 1'b0, wr_sel_i = 1'b0;
  logic [31:0] wr_data_i = '0;
  logic pulse_o, wave_o;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  fdiv_top #(.RST_CTL0(B_CTL0), .RST_CTL1(B_CTL1)) u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i),
    .wr_data_i(wr_data_i), .pulse_o(pulse_o), .wave_o(wave_o)
  );

  function automatic logic [31:0] mk0(input bit ig, input bit og, input bit d,
                                      input int n2, input int n1);
    return {ig, og, 1'b0, d, 4'b0, 12'(n2), 12'(n1)};
  endfunction

  function automatic logic [31:0] mk1(input bit byp, input int m2, input int m1);
    return {7'b0, byp, 12'(m2), 12'(m1)};
  endfunction

  function automatic int eff(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input bit sel, input logic [31:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_sel_i = sel; wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  // Return to a one-cycle single-mode divisor, then load a new setting;
  // on return the current sample is cycle 0 of the new pattern.
  task automatic start(input logic [31:0] c0, input logic [31:0] c1);
    wr(1'b1, mk1(1'b0, 1, 1));
    wr(1'b0, mk0(1'b1, 1'b1, 1'b0, 1, 1));
    repeat (8) @(negedge clk_i);
    wr(1'b1, c1);
    wr(1'b0, c0);
    @(negedge clk_i);
  endtask

  task automatic gap(output int g);
    g = 0;
    do begin
      @(negedge clk_i);
      g++;
    end while (!pulse_o && g < 20000);
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int g, bad;
    repeat (3) @(negedge clk_i);
    chk(pulse_o == 1'b1 && wave_o == 1'b0, "R10 reset", {pulse_o, wave_o}, 2);
    rst_ni = 1'b1;
    bad = 0;
    repeat (4) begin
      @(negedge clk_i);
      if (!(pulse_o == 1'b1 && wave_o == 1'b0)) bad++;
    end
    chk(bad == 0, "R10 first periods", bad, 0);

    // Sweep of small settings, R1 field positions, R2/R3 patterns, R4 zeros, R5 shape
    for (int n1 = 0; n1 <= 4; n1++)
      for (int n2 = 0; n2 <= 3; n2++)
        for (int m1 = 0; m1 <= 2; m1++)
          for (int m2 = 1; m2 <= 2; m2++)
            for (int d = 0; d <= 1; d++) begin
              int en1, en2, em1, em2, len, pos, rep, seg, curn, bp, bw;
              string tg;
              en1 = eff(n1); en2 = eff(n2); em1 = eff(m1); em2 = eff(m2);
              len = 2 * (em1 * en1 + em2 * en2);
              start(mk0(1'b1, 1'b1, d[0], n2, n1), mk1(1'b0, m2, m1));
              pos = 0; rep = 0; seg = 0; curn = en1; bp = 0; bw = 0;
              for (int c = 0; c < len; c++) begin
                if (c != 0) @(negedge clk_i);
                if (pulse_o != (pos == 0)) bp++;
                if (wave_o != (pos < curn / 2)) bw++;
                pos++;
                if (pos == curn) begin
                  pos = 0;
                  if (d == 0) curn = en1;
                  else begin
                    rep++;
                    if (rep == (seg ? em2 : em1)) begin seg ^= 1; rep = 0; end
                    curn = seg ? en2 : en1;
                  end
                end
              end
              tg = (d != 0) ? "R1 R3" : "R1 R2";
              if (n1 == 0 || n2 == 0 || m1 == 0) tg = {tg, " R4"};
              chk(bp == 0, $sformatf("%s pulse n1=%0d n2=%0d m1=%0d m2=%0d", tg, n1, n2, m1, m2), bp, 0);
              chk(bw == 0, $sformatf("R5 level n1=%0d n2=%0d m1=%0d m2=%0d d=%0d", n1, n2, m1, m2, d), bw, 0);
            end

    // R6: divisor change mid-period applies at the next boundary
    start(mk0(1'b1, 1'b1, 1'b0, 1, 8), mk1(1'b0, 1, 1));
    wr(1'b0, mk0(1'b1, 1'b1, 1'b0, 1, 3));
    gap(g);
    chk(g == 6, "R6 old period completes", g, 6);
    gap(g);
    chk(g == 3, "R6 new period", g, 3);

    // R7: input gate freezes the period
    start(mk0(1'b1, 1'b1, 1'b0, 1, 6), mk1(1'b0, 1, 1));
    wr(1'b0, mk0(1'b0, 1'b1, 1'b0, 1, 6));
    bad = 0;
    repeat (3) begin
      @(negedge clk_i);
      if (pulse_o != 1'b0 || wave_o != 1'b1) bad++;
    end
    chk(bad == 0, "R7 frozen outputs", bad, 0);
    wr(1'b0, mk0(1'b1, 1'b1, 1'b0, 1, 6));
    gap(g);
    chk(g == 4, "R7 resumed remainder", g, 4);

    // R8: output gate
    start(mk0(1'b1, 1'b0, 1'b0, 1, 4), mk1(1'b0, 1, 1));
    bad = 0;
    repeat (12) begin
      @(negedge clk_i);
      if (pulse_o || wave_o) bad++;
    end
    chk(bad == 0, "R8 gated low", bad, 0);

    // R9: bypass
    start(mk0(1'b1, 1'b1, 1'b0, 1, 5), mk1(1'b1, 1, 1));
    bad = 0;
    repeat (8) begin
      @(negedge clk_i);
      if (!pulse_o || !wave_o) bad++;
    end
    chk(bad == 0, "R9 bypass high", bad, 0);

    // R11: 32 kHz setting, 19 periods
    start(mk0(1'b1, 1'b1, 1'b1, 732, 733), mk1(1'b0, 11, 8));
    begin
      int cyc, ticks;
      cyc = 0; ticks = 0;
      while (ticks < 19 && cyc < 20000) begin
        @(negedge clk_i);
        cyc++;
        if (pulse_o) ticks++;
      end
      chk(cyc == 13916, "R11 19 periods", cyc, 13916);
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule